// File: doc/BRIEF.md
# Dual-link pixel serializer with mode select

The block takes up to two parallel RGB pixels (8 bits per colour) plus horizontal sync, vertical sync and data-enable. It captures them on a chosen edge of the pixel clock and serialises them onto one or two links. Each link has four data lanes and one clock lane. Every lane carries a 7-bit frame per link clock, most significant slot first. The serial bits are shifted out on a bit clock supplied at seven times the link clock. All logic runs on that bit clock, and the pixel clock is sampled as a level.

A two-bit route select picks one of three modes. In dual mode each pixel goes out on its own link. In split mode the two input pixels leave back-to-back on link 1, so the link clock runs at twice the pixel clock. In single mode only the first pixel is used and link 1 carries it. Extra controls select 6-bit colour (the fourth lane is held low), gate the outputs with an output enable, and gate them with an active-low power-down. Each link reports a driver-enable flag for the pad drivers outside the block.

Top module: `pxl_link_tx`

## Requirements
- R1: While reset is held and in the cycle after it, every data lane and clock lane output of both links is low.
- R2: The clock lane of each enabled link repeats the 7-bit frame 1100011 every 7 bit clocks, leftmost bit first. The data-lane frames start on the same bit clock as the clock-lane frame.
- R3: Within a frame, bit 6 is sent first. Lane 0 carries {R[7:2], G[7]}. Lane 1 carries {G[6:2], B[7:6]}. Lane 2 carries {B[5:2], HS, VS, DE}.
- R4: Lane 3 carries {R[1:0], G[1:0], B[1:0], 0} when six_bit_i is 0. It is all zeros when six_bit_i is 1, and lanes 0 to 2 are unchanged.
- R5: With mode_i = 00, link 1 carries pixel 1 and link 2 carries pixel 2, one frame per pixel clock. Both links have their driver enable high.
- R6: With mode_i = 01, link 1 sends a frame of pixel 1 followed by a frame of pixel 2 for each captured pair. Link 2 is idle: driver enable low and all lanes low.
- R7: With mode_i = 11 or 10, link 1 carries pixel 1 on every frame and link 2 is idle.
- R8: With edge_fall_i = 0 the inputs are captured on a rising edge of pix_clk_i, and with edge_fall_i = 1 on a falling edge. Between capturing edges the captured values are held.
- R9: When oe_i is 0 or pdn_n_i is 0, both driver enables are low and every lane output of both links is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the link clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pix_clk_i | input | 1 | Pixel clock, sampled on clk_i |
| edge_fall_i | input | 1 | 0: capture on rising pixel-clock edge, 1: falling |
| mode_i | input | 2 | 00 dual, 01 split, 11/10 single |
| six_bit_i | input | 1 | 1: 6-bit colour, lane 3 held low |
| oe_i | input | 1 | Output enable, active high |
| pdn_n_i | input | 1 | Power down, active low |
| pix1_r_i | input | 8 | Pixel 1 red |
| pix1_g_i | input | 8 | Pixel 1 green |
| pix1_b_i | input | 8 | Pixel 1 blue |
| pix2_r_i | input | 8 | Pixel 2 red |
| pix2_g_i | input | 8 | Pixel 2 green |
| pix2_b_i | input | 8 | Pixel 2 blue |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| l1_data_o | output | 4 | Link 1 serial data lanes |
| l1_clk_o | output | 1 | Link 1 serial clock lane |
| l1_en_o | output | 1 | Link 1 driver enable |
| l2_data_o | output | 4 | Link 2 serial data lanes |
| l2_clk_o | output | 1 | Link 2 serial clock lane |
| l2_en_o | output | 1 | Link 2 driver enable |

## Verification
The assertions assume that the pixel clock and the bit clock are related: each pixel-clock level lasts at least two bit clocks. They also assume that the pixel inputs are stable in the bit clock that detects the selected edge. The bench derives the pixel clock from the bit clock, with a period of 7 bit clocks in dual and single mode and 14 in split mode. It changes pixel data and controls only on falling bit-clock edges. In the edge-select tests it moves the pixel data only while the pixel clock is held at a steady level.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    localparam int COLOR_W = 8;
    localparam int SER_W   = 7;
    localparam int N_LANES = 4;
    localparam int N_LINKS = 2;
    localparam int MSB_W   = COLOR_W - 2;
    localparam int LSB_W   = 2;
    localparam int HI_W    = 3 * SER_W;
    localparam int SLOT_W  = $clog2(SER_W);

    localparam logic [SER_W-1:0] CLK_FRAME = 7'b1100011;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
    } pixel_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } sync_t;

    typedef logic [N_LANES-1:0][SER_W-1:0] frame_t;

    typedef enum logic [1:0] {
        RT_DUAL   = 2'd0,
        RT_SPLIT  = 2'd1,
        RT_SINGLE = 2'd2
    } route_t;

    function automatic route_t decode_route(input logic [1:0] m);
        case (m)
            2'b00:   return RT_DUAL;
            2'b01:   return RT_SPLIT;
            default: return RT_SINGLE;
        endcase
    endfunction

    // Lanes 0..2 hold the colour MSBs and sync bits; lane 3 the colour LSBs.
    function automatic frame_t pack_frame(input pixel_t p, input sync_t s, input logic six);
        frame_t           f;
        logic [HI_W-1:0]  hi;
        hi = {p.r[COLOR_W-1 -: MSB_W], p.g[COLOR_W-1 -: MSB_W],
              p.b[COLOR_W-1 -: MSB_W], s.hs, s.vs, s.de};
        f[0] = hi[HI_W-1 -: SER_W];
        f[1] = hi[HI_W-SER_W-1 -: SER_W];
        f[2] = hi[SER_W-1:0];
        f[3] = six ? '0 : {p.r[LSB_W-1:0], p.g[LSB_W-1:0], p.b[LSB_W-1:0], 1'b0};
        return f;
    endfunction

endpackage

// File: rtl/pxl_capture.sv
module pxl_capture
    import pxl_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   pix_clk_i,
    input  logic   edge_fall_i,
    input  pixel_t pix1_i,
    input  pixel_t pix2_i,
    input  sync_t  sync_i,
    output pixel_t cap1_o,
    output pixel_t cap2_o,
    output sync_t  sync_o,
    output logic   stb_o
);

    logic pix_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) pix_q <= 1'b0;
        else       pix_q <= pix_clk_i;
    end

    // Selected edge of the sampled pixel clock.
    assign stb_o = edge_fall_i ? (pix_q & ~pix_clk_i) : (~pix_q & pix_clk_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap1_o <= '0;
            cap2_o <= '0;
            sync_o <= '0;
        end else if (stb_o) begin
            cap1_o <= pix1_i;
            cap2_o <= pix2_i;
            sync_o <= sync_i;
        end
    end

    AST_CAPTURE_TAKE: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_o |=> (cap1_o == $past(pix1_i) && cap2_o == $past(pix2_i))); // R8
    AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !stb_o |=> ($stable(cap1_o) && $stable(cap2_o) && $stable(sync_o))); // R8

endmodule

// File: rtl/pxl_framer.sv
module pxl_framer
    import pxl_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  route_t route_i,
    input  logic   six_bit_i,
    input  logic   stb_i,
    input  pixel_t cap1_i,
    input  pixel_t cap2_i,
    input  sync_t  sync_i,
    output logic   load_o,
    output frame_t frame1_o,
    output frame_t frame2_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SER_W - 1);

    logic [SLOT_W-1:0] slot_q;
    logic              fresh_q;
    pixel_t            sel1;

    always_ff @(posedge clk_i) begin
        if (rst_i)                slot_q <= '0;
        else if (slot_q == LAST_SLOT) slot_q <= '0;
        else                      slot_q <= slot_q + 1'b1;
    end

    assign load_o = (slot_q == LAST_SLOT);

    // In split mode a new pair is marked fresh; its first frame consumes the mark.
    always_ff @(posedge clk_i) begin
        if (rst_i)                                  fresh_q <= 1'b0;
        else if (stb_i)                             fresh_q <= 1'b1;
        else if (load_o && route_i == RT_SPLIT)     fresh_q <= 1'b0;
    end

    always_comb begin
        sel1     = cap1_i;
        frame2_o = '0;
        case (route_i)
            RT_DUAL:  frame2_o = pack_frame(cap2_i, sync_i, six_bit_i);
            RT_SPLIT: sel1     = fresh_q ? cap1_i : cap2_i;
            default:  sel1     = cap1_i;
        endcase
        frame1_o = pack_frame(sel1, sync_i, six_bit_i);
    end

    AST_SIX_LANE_D: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_o && six_bit_i) |-> (frame1_o[3] == '0 && frame2_o[3] == '0)); // R4
    AST_LINK2_FRAME_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_o && route_i != RT_DUAL) |-> (frame2_o == '0)); // R7

endmodule

// File: rtl/pxl_link_ser.sv
module pxl_link_ser
    import pxl_pkg::*;
#(
    parameter int LANES = N_LANES,
    parameter int BITS  = SER_W
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             load_i,
    input  logic [LANES-1:0][BITS-1:0]       frame_i,
    input  logic                             en_i,
    output logic [LANES-1:0]                 data_o,
    output logic                             clk_o
);

    logic [BITS-1:0] clk_sh;

    always_ff @(posedge clk_i) begin
        if (rst_i)       clk_sh <= '0;
        else if (load_i) clk_sh <= CLK_FRAME;
        else             clk_sh <= {clk_sh[BITS-2:0], 1'b0};
    end

    assign clk_o = en_i & clk_sh[BITS-1];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BITS-1:0] sh;
        always_ff @(posedge clk_i) begin
            if (rst_i)       sh <= '0;
            else if (load_i) sh <= frame_i[l];
            else             sh <= {sh[BITS-2:0], 1'b0};
        end
        assign data_o[l] = en_i & sh[BITS-1];
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (data_o == '0 && !clk_o)); // R1
    AST_CLK_LEAD: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (clk_o == en_i)); // R2

endmodule

// File: rtl/pxl_link_tx.sv
module pxl_link_tx
    import pxl_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               pix_clk_i,
    input  logic               edge_fall_i,
    input  logic [1:0]         mode_i,
    input  logic               six_bit_i,
    input  logic               oe_i,
    input  logic               pdn_n_i,
    input  logic [COLOR_W-1:0] pix1_r_i,
    input  logic [COLOR_W-1:0] pix1_g_i,
    input  logic [COLOR_W-1:0] pix1_b_i,
    input  logic [COLOR_W-1:0] pix2_r_i,
    input  logic [COLOR_W-1:0] pix2_g_i,
    input  logic [COLOR_W-1:0] pix2_b_i,
    input  logic               hs_i,
    input  logic               vs_i,
    input  logic               de_i,
    output logic [N_LANES-1:0] l1_data_o,
    output logic               l1_clk_o,
    output logic               l1_en_o,
    output logic [N_LANES-1:0] l2_data_o,
    output logic               l2_clk_o,
    output logic               l2_en_o
);

    route_t route;
    pixel_t cap1, cap2;
    sync_t  cap_sync;
    logic   stb, load;
    frame_t frames  [N_LINKS];
    logic   link_en [N_LINKS];
    logic [N_LANES-1:0] lane_out [N_LINKS];
    logic   clk_out [N_LINKS];
    logic   drive;

    assign route = decode_route(mode_i);
    assign drive = oe_i & pdn_n_i;
    assign link_en[0] = drive;
    assign link_en[1] = drive & (route == RT_DUAL);

    pxl_capture u_cap (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pix_clk_i   (pix_clk_i),
        .edge_fall_i (edge_fall_i),
        .pix1_i      ('{r: pix1_r_i, g: pix1_g_i, b: pix1_b_i}),
        .pix2_i      ('{r: pix2_r_i, g: pix2_g_i, b: pix2_b_i}),
        .sync_i      ('{hs: hs_i, vs: vs_i, de: de_i}),
        .cap1_o      (cap1),
        .cap2_o      (cap2),
        .sync_o      (cap_sync),
        .stb_o       (stb)
    );

    pxl_framer u_frm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .route_i   (route),
        .six_bit_i (six_bit_i),
        .stb_i     (stb),
        .cap1_i    (cap1),
        .cap2_i    (cap2),
        .sync_i    (cap_sync),
        .load_o    (load),
        .frame1_o  (frames[0]),
        .frame2_o  (frames[1])
    );

    for (genvar k = 0; k < N_LINKS; k++) begin : g_link
        pxl_link_ser #(.LANES(N_LANES), .BITS(SER_W)) u_ser (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .load_i  (load),
            .frame_i (frames[k]),
            .en_i    (link_en[k]),
            .data_o  (lane_out[k]),
            .clk_o   (clk_out[k])
        );
    end

    assign l1_data_o = lane_out[0];
    assign l1_clk_o  = clk_out[0];
    assign l1_en_o   = link_en[0];
    assign l2_data_o = lane_out[1];
    assign l2_clk_o  = clk_out[1];
    assign l2_en_o   = link_en[1];

    AST_LINK2_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i != 2'b00) |-> (!l2_en_o && l2_data_o == '0 && !l2_clk_o)); // R7
    AST_OUTPUTS_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !(oe_i && pdn_n_i) |-> (!l1_en_o && !l2_en_o && l1_data_o == '0 &&
                                l2_data_o == '0 && !l1_clk_o && !l2_clk_o)); // R9

endmodule

// File: tb/pxl_link_tx_tb.sv
module pxl_link_tx_tb;
    import pxl_pkg::*;

    typedef struct packed {
        logic [1:0] mode;
        logic       six;
        pixel_t     p1;
        pixel_t     p2;
        sync_t      s;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{mode: 2'b00, six: 1'b0, p1: 24'hA53CE7, p2: 24'h1BD248, s: 3'b101},
        '{mode: 2'b00, six: 1'b1, p1: 24'hFF0081, p2: 24'h66990F, s: 3'b011},
        '{mode: 2'b01, six: 1'b0, p1: 24'h123456, p2: 24'hFEDCBA, s: 3'b110},
        '{mode: 2'b01, six: 1'b1, p1: 24'hC37E29, p2: 24'h58A1F6, s: 3'b001},
        '{mode: 2'b11, six: 1'b0, p1: 24'h9D4BE2, p2: 24'h00FF00, s: 3'b111},
        '{mode: 2'b10, six: 1'b0, p1: 24'h3AC571, p2: 24'hFFFFFF, s: 3'b010}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic edge_fall = 1'b0;
    logic [1:0] mode = 2'b00;
    logic six = 1'b0, oe = 1'b1, pdn_n = 1'b1;
    pixel_t p1 = '0, p2 = '0;
    sync_t  sy = '0;
    logic [N_LANES-1:0] l1_data, l2_data;
    logic l1_clk, l1_en, l2_clk, l2_en;

    logic pix_run = 1'b0, pix_man = 1'b0;
    int   pix_div = 7;
    int   pcnt = 0;
    logic pix_clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [6:0] sr1 [4];
    logic [6:0] sr2 [4];
    logic [6:0] sc1 = '0, sc2 = '0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!pix_run)              pcnt <= 0;
        else if (pcnt >= pix_div-1) pcnt <= 0;
        else                        pcnt <= pcnt + 1;
    end
    assign pix_clk = pix_run ? (pcnt < (pix_div + 1) / 2) : pix_man;

    pxl_link_tx u_dut (
        .clk_i(clk), .rst_i(rst), .pix_clk_i(pix_clk), .edge_fall_i(edge_fall),
        .mode_i(mode), .six_bit_i(six), .oe_i(oe), .pdn_n_i(pdn_n),
        .pix1_r_i(p1.r), .pix1_g_i(p1.g), .pix1_b_i(p1.b),
        .pix2_r_i(p2.r), .pix2_g_i(p2.g), .pix2_b_i(p2.b),
        .hs_i(sy.hs), .vs_i(sy.vs), .de_i(sy.de),
        .l1_data_o(l1_data), .l1_clk_o(l1_clk), .l1_en_o(l1_en),
        .l2_data_o(l2_data), .l2_clk_o(l2_clk), .l2_en_o(l2_en)
    );

    // Expected frame {lane3, lane2, lane1, lane0} from the lane map of R3 and R4.
    function automatic logic [27:0] exp_frame(input pixel_t p, input sync_t s, input logic sx);
        logic [6:0] a, b, c, d;
        a = {p.r[7:2], p.g[7]};
        b = {p.g[6:2], p.b[7:6]};
        c = {p.b[5:2], s.hs, s.vs, s.de};
        d = sx ? 7'd0 : {p.r[1:0], p.g[1:0], p.b[1:0], 1'b0};
        return {d, c, b, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sample_bit();
        @(negedge clk);
        for (int l = 0; l < 4; l++) begin
            sr1[l] = {sr1[l][5:0], l1_data[l]};
            sr2[l] = {sr2[l][5:0], l2_data[l]};
        end
        sc1 = {sc1[5:0], l1_clk};
        sc2 = {sc2[5:0], l2_clk};
    endtask

    task automatic grab(output bit found);
        found = 0;
        for (int i = 0; i < 14 && !found; i++) begin
            sample_bit();
            if (sc1 == CLK_FRAME) found = 1;
        end
    endtask

    function automatic logic [27:0] got1();
        return {sr1[3], sr1[2], sr1[1], sr1[0]};
    endfunction
    function automatic logic [27:0] got2();
        return {sr2[3], sr2[2], sr2[1], sr2[0]};
    endfunction

    task automatic link2_idle(input string req);
        chk(!l2_en && l2_data == 4'd0 && !l2_clk && got2() == 28'd0, req,
            28'({l2_en, l2_clk, l2_data}) | got2(), 28'd0);
    endtask

    initial begin
        for (int l = 0; l < 4; l++) begin
            sr1[l] = '0;
            sr2[l] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs low while reset is held
        chk(l1_data == 4'd0 && l2_data == 4'd0 && !l1_clk && !l2_clk, "R1",
            28'({l1_clk, l2_clk, l1_data, l2_data}), 28'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(l1_data == 4'd0 && l2_data == 4'd0 && !l1_clk && !l2_clk, "R1",
            28'({l1_clk, l2_clk, l1_data, l2_data}), 28'd0);
        pix_run = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [27:0] e1, e2, prev;
            bit f;
            @(negedge clk);
            mode = VECS[v].mode; six = VECS[v].six;
            p1 = VECS[v].p1; p2 = VECS[v].p2; sy = VECS[v].s;
            pix_div = (VECS[v].mode == 2'b01) ? 14 : 7;
            e1 = exp_frame(VECS[v].p1, VECS[v].s, VECS[v].six);
            e2 = exp_frame(VECS[v].p2, VECS[v].s, VECS[v].six);
            prev = '0;
            repeat (60) sample_bit();
            for (int k = 0; k < 4; k++) begin
                grab(f);
                chk(f, "R2 link1 clock frame", 28'(sc1), 28'(CLK_FRAME));
                case (VECS[v].mode)
                    2'b00: begin
                        chk(got1() == e1, "R3/R4/R5 link1", got1(), e1);
                        chk(sc2 == CLK_FRAME && got2() == e2, "R3/R4/R5 link2", got2(), e2);
                        chk(l1_en && l2_en, "R5 enables", 28'({l1_en, l2_en}), 28'd3);
                    end
                    2'b01: begin
                        if (k == 0)
                            chk(got1() == e1 || got1() == e2, "R3/R4/R6 first", got1(), e1);
                        else
                            chk(got1() == ((prev == e1) ? e2 : e1), "R3/R4/R6 order",
                                got1(), (prev == e1) ? e2 : e1);
                        prev = got1();
                        link2_idle("R6 link2 idle");
                    end
                    default: begin
                        chk(got1() == e1, "R3/R7 link1", got1(), e1);
                        link2_idle("R7 link2 idle");
                    end
                endcase
            end
        end

        // R9: output enable and power down
        begin
            bit f;
            @(negedge clk);
            mode = 2'b00; oe = 1'b0;
            repeat (10) sample_bit();
            chk(!l1_en && !l2_en && got1() == 28'd0 && got2() == 28'd0 && sc1 == 7'd0,
                "R9 oe low", got1() | got2() | 28'({l1_en, l2_en}), 28'd0);
            oe = 1'b1; pdn_n = 1'b0;
            repeat (10) sample_bit();
            chk(!l1_en && !l2_en && got1() == 28'd0 && got2() == 28'd0 && sc2 == 7'd0,
                "R9 power down", got1() | got2() | 28'({l1_en, l2_en}), 28'd0);
            pdn_n = 1'b1;
            repeat (20) sample_bit();
            grab(f);
            chk(f && l1_en && l2_en, "R9 restored", 28'({f, l1_en, l2_en}), 28'd7);
        end

        // R8: capture edge select, pixel clock held by hand
        for (int es = 0; es < 2; es++) begin
            pixel_t pa, pb;
            logic [27:0] ex;
            bit f;
            pa = 24'h5A69C3; pb = 24'hE1872D;
            @(negedge clk);
            mode = 2'b11; six = 1'b0; sy = 3'b100;
            pix_run = 1'b0; pix_man = 1'b0; edge_fall = es[0];
            p1 = pa;
            repeat (10) @(negedge clk);
            pix_man = 1'b1;
            repeat (10) @(negedge clk);
            p1 = pb;
            repeat (10) @(negedge clk);
            pix_man = 1'b0;
            repeat (10) @(negedge clk);
            p1 = 24'h000000;
            repeat (20) sample_bit();
            grab(f);
            ex = exp_frame(es == 0 ? pa : pb, 3'b100, 1'b0);
            chk(f && got1() == ex, es == 0 ? "R8 rising capture" : "R8 falling capture",
                got1(), ex);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule